// File: doc/BRIEF.md
# Early-Terminating Iterative Signed Multiplier

The block multiplies a multiplicand by an examined operand a few bits at a time, one digit of the examined operand per clock. It stops as soon as everything above the consumed digits is a pure sign extension (all zeros or all ones). The top digit consumed is then treated as a signed digit, so negative operands finish early just as small positive ones do. The latency therefore depends on the data. With the default 32-bit operands and 8-bit digits it takes 1 to 4 cycles. Only the examined operand sets the count, so swapping the two operands leaves the result unchanged but can change the latency.

Four operations are selected by a 2-bit code. Two return the low half of the product, plain or with an added accumulator. Two return the full signed double-width product, plain or with a double-width accumulator added. A caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse; `result` holds its value until the next completion.

The controller has two states. IDLE takes the transition ACCEPT to RUN when `start` is seen, and the operands are latched at that edge. RUN takes ADVANCE (RUN to RUN) while higher digits still carry information. It takes RETIRE (RUN to IDLE) on the cycle whose digit is the last one needed; at that same edge `done` rises and `result` is written.

Top module: `ets_mul`

## Requirements
- R1: With `op` = 0 (low multiply), `result` equals the low DATA_W bits of `opa` times `opb`, with the upper DATA_W bits of `result` zero.
- R2: With `op` = 1 (low multiply-add), `result` equals the low DATA_W bits of `opa` times `opb` plus `acc_in[DATA_W-1:0]`, with the upper DATA_W bits of `result` zero.
- R3: With `op` = 2 (long multiply), `result` equals the full 2*DATA_W-bit product of `opa` and `opb`, both read as two's-complement signed values.
- R4: With `op` = 3 (long multiply-add), `result` equals the signed 2*DATA_W-bit product plus `acc_in`, modulo 2^(2*DATA_W).
- R5: `busy` is high for exactly one cycle after the accepting edge when `opb` bits above the lowest digit (default `opb[31:8]`) are all zeros or all ones.
- R6: `busy` is high for exactly two cycles when R5 does not apply and `opb` bits above the two lowest digits (default `opb[31:16]`) are all zeros or all ones.
- R7: `busy` is high for k cycles when k-1 digits are not enough and the bits above the lowest k digits are uniform. Otherwise it is high for DATA_W/DIGIT_W cycles (default 4), which is never exceeded.
- R8: Exchanging `opa` and `opb` gives the same `result`; the cycle count follows the value on `opb`.
- R9: `done` is a single-cycle pulse in the cycle after the last `busy` cycle, `busy` is low while `done` is high, and `result` changes only at the edge that raises `done`.
- R10: A `start` while `busy` is high is ignored: the running operation completes with its original operands and no further operation begins.
- R11: After reset `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted at an edge where `busy` is low |
| op | input | 2 | Operation: 0 low mul, 1 low mul-add, 2 long mul, 3 long mul-add |
| opa | input | DATA_W | Multiplicand |
| opb | input | DATA_W | Examined operand, consumed one digit per cycle |
| acc_in | input | 2*DATA_W | Accumulator addend |
| busy | output | 1 | High while digits are being consumed |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2*DATA_W | Result, held between completions |

## Verification
The bench builds two instances. The first uses the default 32-bit operands with 8-bit digits and runs directed cases: the operand-swap pair, starts issued while busy, and examined operands with zero, all-ones and mixed upper bytes. The second uses 8-bit operands with 2-bit digits, so it also has four digits. On it, every examined operand value is swept against a set of multiplicands for all four operations. That puts every early-exit boundary and every sign pattern of the examined operand within reach, and both the result and the exact cycle count are checked against arithmetic done in the bench.

// File: rtl/ets_mul_pkg.sv
package ets_mul_pkg;

    // Bit 1 of the code selects the long (double-width) form,
    // bit 0 selects the accumulate form.
    typedef enum logic [1:0] {
        OP_MUL   = 2'd0,
        OP_MLA   = 2'd1,
        OP_SMULL = 2'd2,
        OP_SMLAL = 2'd3
    } op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/ets_mul_digit.sv
// Recodes the examined operand into signed digits and flags, per digit,
// whether all higher bits are sign extension.
module ets_mul_digit #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8,
    parameter int NDIG    = DATA_W / DIGIT_W,
    parameter int IDX_W   = 2
) (
    input  logic [DATA_W-1:0]         mulr,
    input  logic [IDX_W-1:0]          idx,
    output logic signed [DIGIT_W:0]   sdigit,
    output logic                      last
);

    logic signed [DIGIT_W:0] dig_v [NDIG];
    logic [NDIG-1:0]         stop_v;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        localparam int LO = g * DIGIT_W;
        localparam int HI = (g + 1) * DIGIT_W;
        logic neg;
        if (g == NDIG - 1) begin : g_top
            assign neg       = mulr[DATA_W-1];
            assign stop_v[g] = 1'b1;
        end else begin : g_mid
            logic ones, zeros;
            assign ones      = &mulr[DATA_W-1:HI];
            assign zeros     = ~|mulr[DATA_W-1:HI];
            assign neg       = ones;
            assign stop_v[g] = ones | zeros;
        end
        // raw digit minus 2^DIGIT_W when the remainder above is all ones
        assign dig_v[g] = {neg, mulr[LO +: DIGIT_W]};
    end

    always_comb begin
        sdigit = dig_v[idx];
        last   = stop_v[idx];
    end

endmodule

// File: rtl/ets_mul_pp.sv
// One signed partial product, aligned to its digit position.
module ets_mul_pp #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8,
    parameter int IDX_W   = 2
) (
    input  logic [DATA_W-1:0]        mcand,
    input  logic signed [DIGIT_W:0]  sdigit,
    input  logic [IDX_W-1:0]         idx,
    output logic [2*DATA_W-1:0]      pp
);

    localparam int PROD_W = DATA_W + DIGIT_W + 1;

    logic signed [PROD_W-1:0]   prod;
    logic signed [2*DATA_W-1:0] ext;
    logic [31:0]                shamt;

    assign prod  = $signed(mcand) * sdigit;
    assign ext   = prod;
    assign shamt = 32'(idx) * 32'(DIGIT_W);
    assign pp    = ext << shamt;

endmodule

// File: rtl/ets_mul_ctrl.sv
module ets_mul_ctrl
    import ets_mul_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last,
    output logic             busy,
    output logic             load,
    output logic             step,
    output logic             done,
    output logic [IDX_W-1:0] idx
);

    state_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions: ACCEPT, ADVANCE, RETIRE
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_RUN;
            S_RUN:  if (last)  nxt = S_IDLE;
        endcase
    end

    assign load = (state == S_IDLE) && start;
    assign step = (state == S_RUN);
    assign busy = step;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= step && last;
            if (load)      idx <= '0;
            else if (step) idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/ets_mul.sv
module ets_mul
    import ets_mul_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [2*DATA_W-1:0]   acc_in,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   result
);

    localparam int NDIG  = DATA_W / DIGIT_W;
    localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int RES_W = 2 * DATA_W;

    logic                    load, step, last;
    logic [IDX_W-1:0]        idx;
    logic signed [DIGIT_W:0] sdigit;
    logic [RES_W-1:0]        pp, sum_q, sum_nxt, init;
    logic [DATA_W-1:0]       a_q, b_q;
    op_e                     op_q;

    ets_mul_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .last  (last),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .done  (done),
        .idx   (idx)
    );

    ets_mul_digit #(
        .DATA_W(DATA_W), .DIGIT_W(DIGIT_W), .NDIG(NDIG), .IDX_W(IDX_W)
    ) u_digit (
        .mulr   (b_q),
        .idx    (idx),
        .sdigit (sdigit),
        .last   (last)
    );

    ets_mul_pp #(
        .DATA_W(DATA_W), .DIGIT_W(DIGIT_W), .IDX_W(IDX_W)
    ) u_pp (
        .mcand  (a_q),
        .sdigit (sdigit),
        .idx    (idx),
        .pp     (pp)
    );

    always_comb begin
        unique case (op_e'(op))
            OP_MLA:   init = {{DATA_W{1'b0}}, acc_in[DATA_W-1:0]};
            OP_SMLAL: init = acc_in;
            default:  init = '0;
        endcase
    end

    assign sum_nxt = sum_q + pp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            op_q   <= OP_MUL;
            sum_q  <= '0;
            result <= '0;
        end else begin
            if (load) begin
                a_q   <= opa;
                b_q   <= opb;
                op_q  <= op_e'(op);
                sum_q <= init;
            end else if (step) begin
                sum_q <= sum_nxt;
                if (last) begin
                    if (op_q[1]) result <= sum_nxt;
                    else         result <= {{DATA_W{1'b0}}, sum_nxt[DATA_W-1:0]};
                end
            end
        end
    end

endmodule

// File: rtl/ets_mul_checker.sv
module ets_mul_checker #(
    parameter int NDIG  = 4,
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result
);

    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_retire_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < NDIG));

endmodule

bind ets_mul ets_mul_checker #(.NDIG(NDIG), .RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/ets_mul_tb.sv
module ets_mul_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 32, BD = 8;
    localparam int SW = 8,  SD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // default-size instance
    logic            b_start = 1'b0;
    logic [1:0]      b_op = '0;
    logic [BW-1:0]   b_a = '0, b_b = '0;
    logic [2*BW-1:0] b_acc = '0;
    logic            b_busy, b_done;
    logic [2*BW-1:0] b_res;

    // small instance for sweeps
    logic            s_start = 1'b0;
    logic [1:0]      s_op = '0;
    logic [SW-1:0]   s_a = '0, s_b = '0;
    logic [2*SW-1:0] s_acc = '0;
    logic            s_busy, s_done;
    logic [2*SW-1:0] s_res;

    ets_mul #(.DATA_W(BW), .DIGIT_W(BD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(b_start), .op(b_op),
        .opa(b_a), .opb(b_b), .acc_in(b_acc),
        .busy(b_busy), .done(b_done), .result(b_res)
    );

    ets_mul #(.DATA_W(SW), .DIGIT_W(SD)) dut_s (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op(s_op),
        .opa(s_a), .opb(s_b), .acc_in(s_acc),
        .busy(s_busy), .done(s_done), .result(s_res)
    );

    int total = 0;
    int fails = 0;
    bit reported = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_res(input int w, input logic [1:0] op,
                                            input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] acc);
        longint sa, sb;
        logic [63:0] p, mw, m2w;
        sa  = $signed(a << (64 - w)) >>> (64 - w);
        sb  = $signed(b << (64 - w)) >>> (64 - w);
        p   = sa * sb;
        mw  = (64'd1 << w) - 64'd1;
        m2w = (2 * w >= 64) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
        case (op)
            2'd0:    return p & mw;
            2'd1:    return (p + (acc & mw)) & mw;
            2'd2:    return p & m2w;
            default: return (p + acc) & m2w;
        endcase
    endfunction

    function automatic int exp_cyc(input int w, input int d, input logic [63:0] b);
        int n = w / d;
        logic [63:0] bm = b & ((64'd1 << w) - 64'd1);
        for (int k = 1; k < n; k++) begin
            int sh = d * k;
            logic [63:0] up = bm >> sh;
            if (up == 0 || up == ((64'd1 << (w - sh)) - 64'd1)) return k;
        end
        return n;
    endfunction

    function automatic string cyc_tag(input int c);
        if (c == 1) return "R5 cycles";
        if (c == 2) return "R6 cycles";
        return "R7 cycles";
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R1 result";
            2'd1:    return "R2 result";
            2'd2:    return "R3 result";
            default: return "R4 result";
        endcase
    endfunction

    task automatic run_b(input logic [1:0] op, input logic [BW-1:0] a, input logic [BW-1:0] b,
                         input logic [2*BW-1:0] acc,
                         output logic [2*BW-1:0] res, output int cyc);
        logic [2*BW-1:0] held;
        @(negedge clk);
        b_op = op; b_a = a; b_b = b; b_acc = acc; b_start = 1'b1;
        @(negedge clk);
        b_start = 1'b0;
        cyc = 0;
        while (b_busy && cyc < 20) begin
            cyc++;
            @(negedge clk);
        end
        res = b_res;
        check(b_done === 1'b1, "R9 done after busy", 64'(b_done), 64'd1);
        held = b_res;
        @(negedge clk);
        check(b_done === 1'b0 && b_res === held, "R9 single pulse and hold",
              {63'd0, b_done}, 64'd0);
    endtask

    task automatic run_s(input logic [1:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b,
                         input logic [2*SW-1:0] acc,
                         output logic [2*SW-1:0] res, output int cyc);
        @(negedge clk);
        s_op = op; s_a = a; s_b = b; s_acc = acc; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        cyc = 0;
        while (s_busy && cyc < 20) begin
            cyc++;
            @(negedge clk);
        end
        res = s_res;
        check(s_done === 1'b1, "R9 small done", 64'(s_done), 64'd1);
    endtask

    task automatic dir_b(input logic [1:0] op, input logic [BW-1:0] a, input logic [BW-1:0] b,
                         input logic [2*BW-1:0] acc);
        logic [2*BW-1:0] r;
        int c;
        logic [63:0] e;
        int ec;
        run_b(op, a, b, acc, r, c);
        e  = exp_res(BW, op, 64'(a), 64'(b), acc);
        ec = exp_cyc(BW, BD, 64'(b));
        check(r === e, op_tag(op), r, e);
        check(c == ec, cyc_tag(ec), 64'(c), 64'(ec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
        $finish;
    end

    initial begin
        logic [2*BW-1:0] r1, r2;
        int c1, c2;
        logic [SW-1:0] avals [8];

        repeat (3) @(negedge clk);
        // R11 reset state
        check(b_busy === 1'b0 && b_done === 1'b0, "R11 reset flags",
              {62'd0, b_busy, b_done}, 64'd0);
        check(b_res === '0, "R11 reset result", b_res, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R4 and R5..R7 on the default configuration
        dir_b(2'd0, 32'h1234_5678, 32'h0000_007F, 64'd0);
        dir_b(2'd0, 32'hDEAD_BEEF, 32'hFFFF_FF80, 64'd0);
        dir_b(2'd0, 32'h0000_0003, 32'h0000_00FF, 64'd0);
        dir_b(2'd1, 32'h7FFF_FFFF, 32'h0000_1234, 64'hFFFF_FFFF_8000_0001);
        dir_b(2'd1, 32'h8000_0000, 32'hFFFF_8000, 64'h0000_0000_1111_1111);
        dir_b(2'd2, 32'h8000_0000, 32'h8000_0000, 64'd0);
        dir_b(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);
        dir_b(2'd2, 32'h0123_4567, 32'h00AB_CDEF, 64'd0);
        dir_b(2'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        dir_b(2'd3, 32'hF000_0001, 32'hFF80_0000, 64'h0123_4567_89AB_CDEF);
        dir_b(2'd3, 32'h0000_0005, 32'h0000_0000, 64'h8000_0000_0000_0000);

        // R8: exchange operands
        run_b(2'd2, 32'h1234_5678, 32'h0000_0005, 64'd0, r1, c1);
        run_b(2'd2, 32'h0000_0005, 32'h1234_5678, 64'd0, r2, c2);
        check(r1 === r2, "R8 swap result", r2, r1);
        check(c1 == 1 && c2 == 4, "R8 swap cycles", {32'(c1), 32'(c2)}, {32'd1, 32'd4});

        // R10: start while busy is ignored
        @(negedge clk);
        b_op = 2'd0; b_a = 32'd3; b_b = 32'h1234_5678; b_acc = '0; b_start = 1'b1;
        @(negedge clk);
        b_op = 2'd2; b_a = 32'd99; b_b = 32'd1; b_start = 1'b1;
        @(negedge clk);
        b_start = 1'b0;
        c1 = 1;
        while (b_busy && c1 < 20) begin
            c1++;
            @(negedge clk);
        end
        check(b_res === 64'h0000_0000_369D_0368, "R10 original operands kept",
              b_res, 64'h0000_0000_369D_0368);
        check(c1 == 4, "R10 original latency", 64'(c1), 64'd4);
        @(negedge clk);
        check(b_busy === 1'b0, "R10 no second operation", 64'(b_busy), 64'd0);

        // sweep on the small configuration: every opb, all ops
        avals = '{8'h00, 8'h01, 8'hFF, 8'h55, 8'h80, 8'h7F, 8'h03, 8'hFD};
        for (int op = 0; op < 4; op++) begin
            for (int ai = 0; ai < 8; ai++) begin
                for (int bv = 0; bv < 256; bv++) begin
                    logic [2*SW-1:0] rs, acc;
                    logic [63:0] e;
                    int cs, ec;
                    acc = 16'(bv * 37 + op * 1234 + ai * 4099);
                    run_s(2'(op), avals[ai], 8'(bv), acc, rs, cs);
                    e  = exp_res(SW, 2'(op), 64'(avals[ai]), 64'(bv), 64'(acc));
                    ec = exp_cyc(SW, SD, 64'(bv));
                    check(64'(rs) === e, op_tag(2'(op)), 64'(rs), e);
                    check(cs == ec, cyc_tag(ec), 64'(cs), 64'(ec));
                end
            end
        end

        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
        $finish;
    end

endmodule